// File: doc/BRIEF.md
# Threshold-Steered Data FIFO

This block buffers 16-bit data words between a host register port and a card data path. Storage is a circular buffer of 32 words addressed by a read pointer and an occupancy count. Either side may push or pop. A combinational head-word output shows the oldest stored word to both sides.

Two programmable levels watch the occupancy. The almost-full level applies while data is received from the card. The almost-empty level applies while data is transmitted to the card. A per-direction enable bit sends each crossing either to a registered DMA request line or to a status flag. A level is only looked at when the current direction matches it.

A small state machine tracks the transfer context and has three states. `LV_IDLE` means no transfer is active and the buffer is empty. `LV_RX` means receive direction and `LV_TX` means transmit direction. On every clock the next state is chosen from the transfer-active input, the direction input and the occupancy. Any state can move to any other:
- to `LV_IDLE` when idle and empty;
- otherwise to `LV_RX` when `dir_rx` is 1;
- otherwise to `LV_TX`.

The level outputs are registered in the same edge as the state, so they follow a push, pop or configuration write one clock later.

Top module: `lvl_dma_fifo`

## Requirements
- R1: After reset the configuration reads 16'h1F00 (almost-full level 31, almost-empty level 0, both DMA enables 0), and `rx_dma_req`, `tx_dma_req`, `af_flag` and `ae_flag` are 0.
- R2: Words leave in the order they were accepted, and `head_data` shows the oldest stored word whenever the buffer is not empty, across pointer wrap at 32.
- R3: A push while 32 words are stored is ignored, and no stored word is overwritten.
- R4: A pop while the buffer is empty does not move the read pointer, and `head_data` keeps showing the same word.
- R5: When both pushes are asserted in one cycle only the host word is stored. A push and a pop in the same cycle both take effect.
- R6: In `LV_RX`, if the occupancy is greater than the almost-full level, `rx_dma_req` is 1 when the receive DMA enable is set; otherwise `af_flag` is 1. If the occupancy is not above the level, both are 0.
- R7: In `LV_TX`, if the occupancy is less than the almost-empty level, `tx_dma_req` is 1 when the transmit DMA enable is set; otherwise `ae_flag` is 1. If the occupancy is not below the level, both are 0.
- R8: In `LV_RX`, `tx_dma_req` and `ae_flag` are 0. In `LV_TX`, `rx_dma_req` and `af_flag` are 0.
- R9: In `LV_IDLE` both flags are cleared, and both DMA requests keep their previous value.
- R10: The configuration word is laid out as follows: bit 15 receive DMA enable, bits 12:8 almost-full level, bit 7 transmit DMA enable, bits 4:0 almost-empty level. `cfg_rdata` returns it with all other bits 0.
- R11: A configuration write with a DMA enable bit set clears the matching status flag at the same clock edge.
- R12: The flags and requests are registered. They show the effect of a push, pop or configuration write one clock after the edge that applied it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_push | input | 1 | Host pushes `host_wdata` |
| host_wdata | input | 16 | Host write word |
| host_pop | input | 1 | Host removes the head word |
| card_push | input | 1 | Card side pushes `card_wdata` |
| card_wdata | input | 16 | Card write word |
| card_pop | input | 1 | Card side removes the head word |
| head_data | output | 16 | Oldest stored word (word at the read pointer) |
| dir_rx | input | 1 | 1 = receive from card, 0 = transmit to card |
| xfer_active | input | 1 | A data transfer is in progress |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write word |
| cfg_rdata | output | 16 | Current configuration word |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| af_flag | output | 1 | Almost-full status flag |
| ae_flag | output | 1 | Almost-empty status flag |

## Verification
The assertions check, on every cycle, these properties:
- the occupancy never passes 32;
- a push into a full buffer leaves it full;
- a pop from an empty buffer leaves the pointer alone;
- a DMA request and its own flag are never high together;
- the opposite direction's outputs stay low in each state;
- a request rises only while its enable is set;
- an enabling configuration write clears the flag.

Some behaviours can only be shown by the bench's scenarios against its queue model:
- data order across wrap;
- the word shown after an empty pop;
- host priority on a double push;
- one-cycle output latency;
- requests held in `LV_IDLE`.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;
    localparam int LVL_W = 5;

    typedef enum logic [1:0] {
        LV_IDLE = 2'd0,
        LV_RX   = 2'd1,
        LV_TX   = 2'd2
    } lv_state_e;

    typedef struct packed {
        logic             rx_en;
        logic [LVL_W-1:0] af_lvl;
        logic             tx_en;
        logic [LVL_W-1:0] ae_lvl;
    } lv_cfg_t;
endpackage

// File: rtl/lvl_fifo_store.sv
module lvl_fifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  wr_idx;
    logic              push_ok;
    logic              pop_ok;

    assign push_ok = push && (count != FULL_CNT);
    assign pop_ok  = pop && (count != '0);
    assign wr_idx  = rd_ptr + count[PTR_W-1:0];
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_idx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R3
    always_comb begin
        if (rst_n) begin
            count_bound_chk: assert (count <= FULL_CNT);
        end
    end

    // R3
    full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push && !pop) |=> (count == FULL_CNT));

    // R4
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push) |=> ($stable(rd_ptr) && count == '0));
endmodule

// File: rtl/lvl_level_ctrl.sv
module lvl_level_ctrl
    import lvl_fifo_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             xfer_active,
    input  logic             dir_rx,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output lv_cfg_t          cfg_q,
    output logic             rx_dma_req,
    output logic             tx_dma_req,
    output logic             af_flag,
    output logic             ae_flag
);
    lv_state_e st, st_nxt;
    lv_cfg_t   cfg_new;
    logic      over_af;
    logic      under_ae;

    assign cfg_new.rx_en  = cfg_wdata[15];
    assign cfg_new.af_lvl = cfg_wdata[12:8];
    assign cfg_new.tx_en  = cfg_wdata[7];
    assign cfg_new.ae_lvl = cfg_wdata[4:0];

    assign over_af  = count > CNT_W'(cfg_q.af_lvl);
    assign under_ae = count < CNT_W'(cfg_q.ae_lvl);

    always_comb begin
        if (!xfer_active && count == '0) begin
            st_nxt = LV_IDLE;
        end else if (dir_rx) begin
            st_nxt = LV_RX;
        end else begin
            st_nxt = LV_TX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= LV_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '{rx_en: 1'b0, af_lvl: 5'h1f, tx_en: 1'b0, ae_lvl: 5'h00};
            rx_dma_req <= 1'b0;
            tx_dma_req <= 1'b0;
            af_flag    <= 1'b0;
            ae_flag    <= 1'b0;
        end else begin
            unique case (st_nxt)
                LV_IDLE: begin
                    af_flag <= 1'b0;
                    ae_flag <= 1'b0;
                end
                LV_RX: begin
                    rx_dma_req <= cfg_q.rx_en && over_af;
                    af_flag    <= !cfg_q.rx_en && over_af;
                    tx_dma_req <= 1'b0;
                    ae_flag    <= 1'b0;
                end
                LV_TX: begin
                    tx_dma_req <= cfg_q.tx_en && under_ae;
                    ae_flag    <= !cfg_q.tx_en && under_ae;
                    rx_dma_req <= 1'b0;
                    af_flag    <= 1'b0;
                end
                default: begin
                    af_flag <= 1'b0;
                    ae_flag <= 1'b0;
                end
            endcase
            if (cfg_we) begin
                cfg_q <= cfg_new;
                if (cfg_new.rx_en) af_flag <= 1'b0;
                if (cfg_new.tx_en) ae_flag <= 1'b0;
            end
        end
    end

    // R6
    rx_req_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req && af_flag));

    // R7
    tx_req_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req && ae_flag));

    // R8
    rx_side_quiet_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LV_TX) |-> (!rx_dma_req && !af_flag));

    // R8
    tx_side_quiet_in_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LV_RX) |-> (!tx_dma_req && !ae_flag));

    // R6
    rx_req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dma_req) |-> $past(cfg_q.rx_en));

    // R11
    cfg_clears_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[15]) |=> !af_flag);

    // R11
    cfg_clears_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[7]) |=> !ae_flag);
endmodule

// File: rtl/lvl_dma_fifo.sv
module lvl_dma_fifo
    import lvl_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_push,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_pop,
    input  logic              card_push,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_pop,
    output logic [DATA_W-1:0] head_data,
    input  logic              dir_rx,
    input  logic              xfer_active,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              af_flag,
    output logic              ae_flag
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic              any_push;
    logic              any_pop;
    logic [DATA_W-1:0] push_word;
    logic [CNT_W-1:0]  occ;
    lv_cfg_t           cfg_q;

    assign any_push  = host_push || card_push;
    assign any_pop   = host_pop || card_pop;
    assign push_word = host_push ? host_wdata : card_wdata;
    assign cfg_rdata = {cfg_q.rx_en, 2'b00, cfg_q.af_lvl, cfg_q.tx_en, 2'b00, cfg_q.ae_lvl};

    lvl_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (any_push),
        .wdata (push_word),
        .pop   (any_pop),
        .rdata (head_data),
        .count (occ)
    );

    lvl_level_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .count       (occ),
        .xfer_active (xfer_active),
        .dir_rx      (dir_rx),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_q       (cfg_q),
        .rx_dma_req  (rx_dma_req),
        .tx_dma_req  (tx_dma_req),
        .af_flag     (af_flag),
        .ae_flag     (ae_flag)
    );
endmodule

// File: tb/lvl_dma_fifo_tb.sv
module lvl_dma_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_push = 0, host_pop = 0, card_push = 0, card_pop = 0;
    logic [15:0] host_wdata = 0, card_wdata = 0;
    logic        dir_rx = 0, xfer_active = 0, cfg_we = 0;
    logic [15:0] cfg_wdata = 0;
    logic [15:0] head_data, cfg_rdata;
    logic        rx_dma_req, tx_dma_req, af_flag, ae_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    int q[$];
    bit m_rxen = 0, m_txen = 0;
    int m_af = 31, m_ae = 0;
    bit m_rxr = 0, m_txr = 0, m_aff = 0, m_aef = 0;
    logic [15:0] saved;

    always #2 clk = ~clk;

    lvl_dma_fifo dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
        .head_data(head_data), .dir_rx(dir_rx), .xfer_active(xfer_active),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .af_flag(af_flag), .ae_flag(ae_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int m_cfg();
        return (int'(m_rxen) << 15) | (m_af << 8) | (int'(m_txen) << 7) | m_ae;
    endfunction

    task automatic tick();
        int n;
        bool_blk: begin
            @(posedge clk);
            n = q.size();
            if (!xfer_active && n == 0) begin
                m_aff = 0; m_aef = 0;
            end else if (dir_rx) begin
                m_rxr = m_rxen && (n > m_af);
                m_aff = !m_rxen && (n > m_af);
                m_txr = 0; m_aef = 0;
            end else begin
                m_txr = m_txen && (n < m_ae);
                m_aef = !m_txen && (n < m_ae);
                m_rxr = 0; m_aff = 0;
            end
            if (cfg_we) begin
                m_rxen = cfg_wdata[15]; m_af = int'(cfg_wdata[12:8]);
                m_txen = cfg_wdata[7];  m_ae = int'(cfg_wdata[4:0]);
                if (m_rxen) m_aff = 0;
                if (m_txen) m_aef = 0;
            end
            if ((host_pop || card_pop) && n > 0) void'(q.pop_front());
            if ((host_push || card_push) && n < 32)
                q.push_back(host_push ? int'(host_wdata) : int'(card_wdata));
            @(negedge clk);
            chk(rx_dma_req == m_rxr, "R6 rx_dma_req", rx_dma_req, m_rxr);
            chk(af_flag == m_aff, "R6 af_flag", af_flag, m_aff);
            chk(tx_dma_req == m_txr, "R7 tx_dma_req", tx_dma_req, m_txr);
            chk(ae_flag == m_aef, "R7 ae_flag", ae_flag, m_aef);
            chk(int'(cfg_rdata) == m_cfg(), "R10 cfg_rdata", cfg_rdata, m_cfg());
            if (q.size() > 0) chk(int'(head_data) == q[0], "R2 head_data", head_data, q[0]);
            host_push = 0; host_pop = 0; card_push = 0; card_pop = 0; cfg_we = 0;
        end
    endtask

    task automatic hpush(input logic [15:0] d); host_push = 1; host_wdata = d; tick(); endtask
    task automatic cpush(input logic [15:0] d); card_push = 1; card_wdata = d; tick(); endtask
    task automatic hpop(); host_pop = 1; tick(); endtask
    task automatic cpop(); card_pop = 1; tick(); endtask
    task automatic wcfg(input logic [15:0] w); cfg_we = 1; cfg_wdata = w; tick(); endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(cfg_rdata == 16'h1F00, "R1 cfg", cfg_rdata, 16'h1F00);
        chk({rx_dma_req, tx_dma_req, af_flag, ae_flag} == 4'b0, "R1 outs",
            {rx_dma_req, tx_dma_req, af_flag, ae_flag}, 0);
        tick();

        // receive direction, flag mode, af level 3, ae level 2
        dir_rx = 1; xfer_active = 1;
        wcfg(16'h0302);
        for (int i = 0; i < 4; i++) cpush(16'h5000 + 16'(i));
        // R12: count became 4 at the last edge, flag not yet updated
        chk(af_flag == 1'b0, "R12 af latency", af_flag, 0);
        tick();
        chk(af_flag == 1'b1, "R6 af set", af_flag, 1);
        // R11: enabling rx DMA clears the flag at the write edge
        wcfg(16'h8302);
        chk(af_flag == 1'b0, "R11 af clear", af_flag, 0);
        tick();
        chk(rx_dma_req == 1'b1, "R6 rx req", rx_dma_req, 1);
        chk(tx_dma_req == 1'b0 && ae_flag == 1'b0, "R8 rx dir", {tx_dma_req, ae_flag}, 0);
        cpush(16'h5004);
        chk(head_data == 16'h5000, "R2 order", head_data, 16'h5000);
        while (q.size() > 0) hpop();
        tick();

        // transmit direction, flag mode, ae level 4, af level 0
        dir_rx = 0;
        wcfg(16'h0004);
        tick();
        chk(ae_flag == 1'b1, "R7 ae set", ae_flag, 1);
        for (int i = 0; i < 6; i++) hpush(16'h6000 + 16'(i));
        tick();
        chk(rx_dma_req == 1'b0 && af_flag == 1'b0, "R8 tx dir", {rx_dma_req, af_flag}, 0);
        chk(ae_flag == 1'b0, "R7 ae clear", ae_flag, 0);
        while (q.size() > 0) cpop();
        tick();
        xfer_active = 0;
        tick();
        chk(ae_flag == 1'b0, "R9 idle flags", ae_flag, 0);

        // R9: requests hold while idle
        xfer_active = 1;
        wcfg(16'h0084);
        chk(ae_flag == 1'b0, "R11 ae clear", ae_flag, 0);
        tick();
        chk(tx_dma_req == 1'b1, "R7 tx req", tx_dma_req, 1);
        xfer_active = 0;
        tick(); tick();
        chk(tx_dma_req == 1'b1, "R9 req hold", tx_dma_req, 1);
        xfer_active = 1;

        // R3 / R4: fill, overfill, drain, empty pop
        wcfg(16'h1F00);
        for (int i = 0; i < 32; i++) hpush(16'hA000 + 16'(i));
        hpush(16'hBEEF);
        while (q.size() > 1) cpop();
        chk(head_data == 16'hA01F, "R3 last word", head_data, 16'hA01F);
        cpop();
        saved = head_data;
        chk(head_data == 16'hA000, "R4 wrap slot", head_data, 16'hA000);
        hpop();
        chk(head_data == saved, "R4 empty pop", head_data, saved);
        hpush(16'h1234);
        chk(head_data == 16'h1234, "R4 pointer kept", head_data, 16'h1234);

        // R5: double push and push with pop
        host_push = 1; host_wdata = 16'h1111; card_push = 1; card_wdata = 16'h2222;
        tick();
        hpop();
        chk(head_data == 16'h1111, "R5 host priority", head_data, 16'h1111);
        card_push = 1; card_wdata = 16'h3333; host_pop = 1;
        tick();
        chk(head_data == 16'h3333, "R5 push with pop", head_data, 16'h3333);
        hpop();
        dir_rx = 1;
        tick(); tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule